// File: doc/BRIEF.md
# One-Shot Two-Phase PWM Timer

This block is a 16-bit down-counter that draws a single PWM pulse and then halts. Two reload values set the length of the two phases. When the timer starts, the counter takes the first reload value and counts down once per count tick. When it passes zero, it takes the second value for the second phase. When it passes zero again, it stops. An output flip-flop changes level at the end of each phase. After the second phase ends, the block raises an interrupt pulse, a DMA pulse and a sticky status flag.

Software starts or stops the timer through a plain register port: one write strobe, one address and combinational read data. A hardware start input can also start it. Each underflow sends a one-clock start pulse to chained timers at once. The flip-flop change and the end-of-run requests wait one extra count tick. During that tick the block decides whether a reload value of all ones is present. Such a value holds the output level, which gives 0% or 100% duty.

Top module: `oneshot_pwm_timer`

## Requirements
- R1: While idle, a write to address 0 with bit 0 set, or a high `ext_start`, starts the timer. On that edge the counter loads reload A (address 1) and does not count. While the timer runs, both start sources are ignored and the counter is not reloaded.
- R2: While running, the counter changes only on clock edges where `cnt_tick` is high. With `cnt_tick` low, it holds its value.
- R3: Phase one lasts reload A + 1 ticks and phase two lasts reload B (address 2) + 1 ticks. On the tick that ends phase one, the counter (address 3) reads 16'hFFFF, and on the next tick it reads B − 1. After the tick that ends phase two, the counter reads 16'hFFFF and the run bit (address 0, bit 0) is 0. The phase bit (address 0, bit 1) is 0 in phase one and 1 in phase two.
- R4: `chain_start` is high for one clock after each of the two underflow edges, with no added delay.
- R5: `pwm_out` changes level on the count tick after each underflow and at no other time. Starting the timer does not change it.
- R6: If the reload value of the phase that just ended is 16'hFFFF, the level change for that underflow is suppressed. The phase still ends.
- R7: `irq_req` and `dma_req` pulse high together for one clock, on the count tick after the second underflow. At the same time the done flag (address 0, bit 4) is set. It stays set until a write to address 0 with bit 4 set clears it.
- R8: A write to address 0 with bit 1 set stops the timer on that edge and cancels any pending level change or request. When a stop and a start arrive on the same edge, the stop wins.
- R9: A write to address 0 with bit 2 set loads bit 3 into `pwm_out`, but only while the timer is idle. While it runs, the write has no effect on `pwm_out`. `pwm_out` can also be read at address 0, bit 3.
- R10: Reset clears the reload values, the counter, the control state and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count-clock enable |
| ext_start | input | 1 | Hardware start request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| pwm_out | output | 1 | Flip-flop waveform output |
| irq_req | output | 1 | Interrupt request pulse |
| dma_req | output | 1 | DMA request pulse |
| chain_start | output | 1 | Start pulse for chained timers |

## Verification
Take the start edge as E0, and assume one tick per clock. Then the underflows fall on edges E(A+1) and E(A+B+2). `chain_start` is high in the cycle after each of those edges. The level change and the request pulses come one edge later still. The bench compares every cycle of a run, from E0 to two cycles past the end, against those formulas. It samples at the falling edge and sets the read address just after it, so each register output is seen once it has settled. Stop, idle-preset and tick-gating cases are checked one cycle after the write or gap that could disturb them.

// File: rtl/oneshot_pwm_timer.sv
module oneshot_pwm_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_tick,
  input  logic          ext_start,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          pwm_out,
  output logic          irq_req,
  output logic          dma_req,
  output logic          chain_start
);
  localparam logic [CW-1:0] ALL1 = '1;

  logic [CW-1:0] rld_a, rld_b, cnt;
  logic running, phase, reload_due, tog_due, tog_en, fin_due, done;

  wire          ctrl_wr   = reg_wr && reg_addr == 2'd0;
  wire          stop_req  = ctrl_wr && reg_wdata[1];
  wire          start_req = !running && !stop_req && ((ctrl_wr && reg_wdata[0]) || ext_start);
  wire [CW-1:0] eff       = reload_due ? rld_b : cnt;
  wire          step      = running && cnt_tick && !stop_req;
  wire          uflow     = step && eff == '0;
  wire          resolve   = tog_due && cnt_tick && !stop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_a <= '0; rld_b <= '0; cnt <= '0;
      running <= 1'b0; phase <= 1'b0; reload_due <= 1'b0;
      tog_due <= 1'b0; tog_en <= 1'b0; fin_due <= 1'b0; done <= 1'b0;
      pwm_out <= 1'b0; irq_req <= 1'b0; dma_req <= 1'b0; chain_start <= 1'b0;
    end else begin
      chain_start <= uflow;
      irq_req     <= 1'b0;
      dma_req     <= 1'b0;
      if (reg_wr && reg_addr == 2'd1) rld_a <= reg_wdata;
      if (reg_wr && reg_addr == 2'd2) rld_b <= reg_wdata;
      if (ctrl_wr && reg_wdata[4]) done <= 1'b0;
      if (ctrl_wr && reg_wdata[2] && !running) pwm_out <= reg_wdata[3];
      if (resolve) begin
        tog_due <= 1'b0;
        if (tog_en) pwm_out <= ~pwm_out;
        if (fin_due) begin
          irq_req <= 1'b1;
          dma_req <= 1'b1;
          done    <= 1'b1;
        end
      end
      if (stop_req) begin
        running    <= 1'b0;
        reload_due <= 1'b0;
        tog_due    <= 1'b0;
      end else if (start_req) begin
        running    <= 1'b1;
        phase      <= 1'b0;
        reload_due <= 1'b0;
        cnt        <= rld_a;
      end else if (step) begin
        if (uflow) begin
          cnt     <= ALL1;
          tog_due <= 1'b1;
          tog_en  <= (phase ? rld_b : rld_a) != ALL1;
          fin_due <= phase;
          if (phase) begin
            running    <= 1'b0;
            reload_due <= 1'b0;
          end else begin
            phase      <= 1'b1;
            reload_due <= 1'b1;
          end
        end else begin
          cnt        <= eff - 1'b1;
          reload_due <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[0] = running;
        reg_rdata[1] = phase;
        reg_rdata[3] = pwm_out;
        reg_rdata[4] = done;
      end
      2'd1: reg_rdata = rld_a;
      2'd2: reg_rdata = rld_b;
      default: reg_rdata = cnt;
    endcase
  end
endmodule

// File: rtl/oneshot_pwm_timer_chk.sv
module oneshot_pwm_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_tick,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [CW-1:0] reg_wdata,
  input logic          running,
  input logic          tog_due,
  input logic [CW-1:0] cnt,
  input logic          pwm_out,
  input logic          irq_req,
  input logic          dma_req,
  input logic          done
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req); // R7
  AST_REQ_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req || dma_req) |-> (done && irq_req && dma_req)); // R7
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !cnt_tick && !reg_wr) |=> $stable(cnt)); // R2
  AST_NO_TOGGLE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(running) && !$past(tog_due) && !$past(reg_wr)) |-> $stable(pwm_out)); // R5
  AST_STOP_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[1]) |=> !running); // R8
endmodule

bind oneshot_pwm_timer oneshot_pwm_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .running(running),
  .tog_due(tog_due), .cnt(cnt), .pwm_out(pwm_out), .irq_req(irq_req),
  .dma_req(dma_req), .done(done)
);

// File: tb/oneshot_pwm_timer_test.sv
module oneshot_pwm_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, cnt_tick = 1'b0, ext_start = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic pwm_out, irq_req, dma_req, chain_start;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  oneshot_pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .ext_start(ext_start),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq_req(irq_req),
    .dma_req(dma_req), .chain_start(chain_start)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R10 reg", int'(v), 0);
    end
    check("R10 outputs", int'({pwm_out, irq_req, dma_req, chain_start}), 0);
  endtask

  task automatic t_trace(input int r0, input int r1, input bit lvl, input string req);
    logic [15:0] v;
    int u1, u2, ecnt, epwm;
    bit erun;
    u1 = r0 + 1;
    u2 = r0 + r1 + 2;
    wr(2'd1, r0[15:0]);
    wr(2'd2, r1[15:0]);
    wr(2'd0, 16'h0014 | (16'(lvl) << 3));
    @(negedge clk);
    cnt_tick = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0001;
    @(negedge clk);
    reg_wr = 1'b0;
    for (int k = 0; k <= u2 + 2; k++) begin
      if (k > 0) @(negedge clk);
      if (k < u1) ecnt = r0 - k;
      else if (k == u1 || k >= u2) ecnt = 16'hFFFF;
      else ecnt = r1 - (k - u1);
      epwm = lvl ^ ((k >= u1 + 1 && r0 != 16'hFFFF) ? 1 : 0)
                 ^ ((k >= u2 + 1 && r1 != 16'hFFFF) ? 1 : 0);
      erun = k < u2;
      rd(2'd3, v);
      check({req, " R3 counter"}, int'(v), ecnt);
      rd(2'd0, v);
      check({req, " R1/R3 run"}, int'(v[0]), int'(erun));
      check({req, " R5/R6 pwm"}, int'(pwm_out), epwm);
      check({req, " R4 chain"}, int'(chain_start), int'(k == u1 || k == u2));
      check({req, " R7 irq/dma"}, int'({irq_req, dma_req}), (k == u2 + 1) ? 3 : 0);
    end
    cnt_tick = 1'b0;
    rd(2'd0, v);
    check({req, " R7 done set"}, int'(v[4]), 1);
    wr(2'd0, 16'h0010);
    rd(2'd0, v);
    check({req, " R7 done cleared"}, int'(v[4]), 0);
  endtask

  task automatic t_tick_gate();
    logic [15:0] v;
    wr(2'd1, 16'd10);
    wr(2'd2, 16'd10);
    wr(2'd0, 16'h0001);
    repeat (4) @(negedge clk);
    rd(2'd3, v);
    check("R2 hold without tick", int'(v), 10);
    for (int i = 0; i < 3; i++) begin
      cnt_tick = 1'b1;
      @(negedge clk);
      cnt_tick = 1'b0;
      @(negedge clk);
    end
    rd(2'd3, v);
    check("R2 three ticks", int'(v), 7);
    wr(2'd0, 16'h0002);
  endtask

  task automatic t_ext_and_stop();
    logic [15:0] v;
    bit p0;
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd5);
    @(negedge clk);
    ext_start = 1'b1;
    @(negedge clk);
    ext_start = 1'b0;
    rd(2'd3, v);
    check("R1 ext start load", int'(v), 5);
    rd(2'd0, v);
    check("R1 ext start run", int'(v[0]), 1);
    cnt_tick = 1'b1;
    repeat (2) @(negedge clk);
    ext_start = 1'b1;
    @(negedge clk);
    ext_start = 1'b0;
    rd(2'd3, v);
    check("R1 ext start ignored while running", int'(v), 2);
    cnt_tick = 1'b0;
    p0 = pwm_out;
    wr(2'd0, 16'h0002);
    rd(2'd0, v);
    check("R8 stop clears run", int'(v[0]), 0);
    rd(2'd3, v);
    check("R8 counter frozen", int'(v), 2);
    cnt_tick = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R8 no requests after stop", int'({irq_req, chain_start}), 0);
    end
    cnt_tick = 1'b0;
    check("R8 pwm unchanged after stop", int'(pwm_out), int'(p0));
  endtask

  task automatic t_stop_wins();
    logic [15:0] v;
    @(negedge clk);
    ext_start = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0003;
    @(negedge clk);
    ext_start = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v);
    check("R8 stop beats start", int'(v[0]), 0);
  endtask

  task automatic t_preset();
    logic [15:0] v;
    wr(2'd0, 16'h0004);
    check("R9 preset low idle", int'(pwm_out), 0);
    wr(2'd1, 16'd20);
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'h000C);
    check("R9 preset ignored while running", int'(pwm_out), 0);
    rd(2'd0, v);
    check("R9 read level bit", int'(v[3]), 0);
    wr(2'd0, 16'h0002);
    wr(2'd0, 16'h000C);
    check("R9 preset high idle", int'(pwm_out), 1);
    rd(2'd0, v);
    check("R9 read level bit high", int'(v[3]), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_trace(3, 5, 1'b0, "R1");
    t_trace(0, 0, 1'b1, "R3 min");
    t_trace(6, 2, 1'b1, "R5");
    t_tick_gate();
    t_ext_and_stop();
    t_stop_wins();
    t_preset();
    t_trace(16'hFFFF, 2, 1'b0, "R6");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule